// File: doc/BRIEF.md
# Interlaced LCD Row Scan Sequencer

This block generates the common-electrode select sequence for a multiplexed dot-matrix LCD of up to 34 rows. A timing tick from the display clock domain moves the scan forward by one row. The rows of a frame are visited in interlaced order: first every even-numbered row in ascending order, then every odd-numbered row in ascending order. A column-data fetch stage uses the registered row index, the one-hot row select vector and a one-cycle frame-start pulse that comes with row 0.

The number of scanned rows comes from a 2-bit rate code, which selects 17, 26 or 34 rows. A separate icon mode scans only rows 0 and 1 and divides the tick by a fixed prescaler to lower the switching rate. Rate and mode inputs are sampled only when a frame begins, so a frame in progress always completes with the settings it started with. While power-down is asserted, or while the display is disabled, every output stays inactive. When the scan resumes, a fresh frame starts at row 0.

Top module: `lcd_row_scan`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `row_sel` is all zero and `frame_start` and `row_valid` are 0. The rate setting taken after reset, if no other code is applied, is 17 rows.
- R2: For an active row count N that is not in icon mode, one frame selects row indices 0,2,4,…, then 1,3,5,…, covering 0..N-1 exactly once. `row_sel` has bit `row_idx` set and no other bit set, and `row_valid` is 1.
- R3: The rate code `mux_code` picks N: 0 gives 17, 1 gives 26, 2 gives 34, and 3 also gives 34. `row_sel` bits at N and above stay 0.
- R4: The scan advances by one position only in a cycle where `tick` is 1. Without a tick the outputs hold their value.
- R5: `frame_start` is 1 for exactly the one cycle in which the scan enters row 0 at the start of a frame, and is 0 at every other time.
- R6: With `icon_mode`=1 at a frame boundary, frames contain only rows 0 and 1. After the first row of a run, each following step occurs on every ICON_DIV-th tick (default 4).
- R7: While `power_down`=1 or `disp_en`=0, the cycle that follows has all outputs at 0. On the first tick after both conditions clear, a frame starts at row 0.
- R8: A change of `mux_code` or `icon_mode` during a frame has no effect until the next frame start. The current frame completes with its original row count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display timing clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Scan step enable, one cycle per row period |
| mux_code | input | 2 | Rate code: 0→17, 1→26, 2/3→34 rows |
| icon_mode | input | 1 | Two-row slow scan when 1 |
| power_down | input | 1 | Forces all outputs inactive when 1 |
| disp_en | input | 1 | Display enable; 0 blanks all rows |
| row_sel | output | 34 | One-hot selected row |
| row_idx | output | 6 | Index of the selected row |
| row_valid | output | 1 | A row is currently selected |
| frame_start | output | 1 | One-cycle pulse when row 0 begins a frame |

## Verification
The hardest case to reach is a rate or mode change that arrives in the middle of a frame, in particular while the scan is crossing from the even half to the odd half. There the old row count decides whether the next row is an odd index or a higher even index. The stimulus changes `mux_code` several ticks into a 17-row frame and later switches `icon_mode` partway through a 34-row frame. A behavioural model rebuilds its own row-order queue only when a frame starts, and it is compared with the outputs on every cycle. Phases with sparse ticks and with power-down or display-disable in mid-frame test the hold and restart behaviour.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int ROWS_MAX = 34;
  localparam int IDX_W    = $clog2(ROWS_MAX + 1);
  localparam int RATE_A   = 17;
  localparam int RATE_B   = 26;
  localparam int RATE_C   = 34;
  localparam int ICON_ROWS = 2;

  typedef struct packed {
    logic [IDX_W-1:0] nrows;
    logic             icon;
  } scan_cfg_t;

  function automatic scan_cfg_t decode_cfg(input logic [1:0] code, input logic icon);
    scan_cfg_t c;
    c.icon = icon;
    if (icon)
      c.nrows = IDX_W'(ICON_ROWS);
    else begin
      case (code)
        2'd0:    c.nrows = IDX_W'(RATE_A);
        2'd1:    c.nrows = IDX_W'(RATE_B);
        default: c.nrows = IDX_W'(RATE_C);
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic active,
  input  logic slow,
  output logic step
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;

  assign step = tick && (!active || !slow || cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || step)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(DIV)) else $error("prescaler overflow"); // R6
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  scan_cfg_t        cfg_in,
  output scan_cfg_t        cfg,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             frame_q,
  output logic             nxt_active,
  output logic [IDX_W-1:0] nxt_idx
);
  logic             nxt_frame;
  logic             load;
  logic [IDX_W:0]   idx_plus2;
  logic             past_end;
  logic             last_row;

  assign idx_plus2 = {1'b0, idx} + (IDX_W+1)'(2);
  assign past_end  = idx_plus2 >= {1'b0, cfg.nrows};
  assign last_row  = idx[0] && past_end;

  always_comb begin
    nxt_active = active;
    nxt_idx    = idx;
    nxt_frame  = 1'b0;
    load       = 1'b0;
    if (!run) begin
      nxt_active = 1'b0;
      nxt_idx    = '0;
    end else if (step) begin
      if (!active || last_row) begin
        load       = 1'b1;
        nxt_active = 1'b1;
        nxt_idx    = '0;
        nxt_frame  = 1'b1;
      end else if (!idx[0] && past_end) begin
        nxt_idx = IDX_W'(1);
      end else begin
        nxt_idx = idx_plus2[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      frame_q <= 1'b0;
      cfg     <= decode_cfg(2'd0, 1'b0);
    end else begin
      active  <= nxt_active;
      idx     <= nxt_idx;
      frame_q <= nxt_frame;
      if (load)
        cfg <= cfg_in;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> idx < cfg.nrows) else $error("row index out of range"); // R3
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !step && active) |=> $stable(idx)) else $error("moved without step"); // R4
  AST_ICON_TWO_ROWS: assert property (@(posedge clk) disable iff (rst)
    (active && cfg.icon) |-> idx <= IDX_W'(1)) else $error("icon row out of range"); // R6
  AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_q |-> $stable(cfg)) else $error("config changed mid-frame"); // R8
endmodule

// File: rtl/row_driver.sv
module row_driver
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_active,
  input  logic [IDX_W-1:0] nxt_idx,
  output logic [ROWS_MAX-1:0] row_sel
);
  for (genvar i = 0; i < ROWS_MAX; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        row_sel[i] <= 1'b0;
      else
        row_sel[i] <= nxt_active && (nxt_idx == IDX_W'(i));
    end
  end

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel)) else $error("multiple rows selected"); // R2
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int ICON_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [1:0]          mux_code,
  input  logic                icon_mode,
  input  logic                power_down,
  input  logic                disp_en,
  output logic [ROWS_MAX-1:0] row_sel,
  output logic [IDX_W-1:0]    row_idx,
  output logic                row_valid,
  output logic                frame_start
);
  logic             run;
  logic             step;
  logic             active;
  logic             frame_q;
  logic             nxt_active;
  logic [IDX_W-1:0] nxt_idx;
  logic [IDX_W-1:0] idx;
  scan_cfg_t        cfg;
  scan_cfg_t        cfg_in;

  assign run    = !power_down && disp_en;
  assign cfg_in = decode_cfg(mux_code, icon_mode);

  scan_prescaler #(.DIV(ICON_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .active(active), .slow(cfg.icon), .step(step)
  );

  scan_sequencer u_seq (
    .clk(clk), .rst(rst), .run(run), .step(step), .cfg_in(cfg_in),
    .cfg(cfg), .active(active), .idx(idx), .frame_q(frame_q),
    .nxt_active(nxt_active), .nxt_idx(nxt_idx)
  );

  row_driver u_drv (
    .clk(clk), .rst(rst), .nxt_active(nxt_active), .nxt_idx(nxt_idx),
    .row_sel(row_sel)
  );

  assign row_idx     = idx;
  assign row_valid   = active;
  assign frame_start = frame_q;

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !run |=> (row_sel == '0 && !row_valid && !frame_start)) else $error("driven while off"); // R7
  AST_FRAME_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_sel[0] && row_idx == '0)) else $error("frame start not at row 0"); // R5
endmodule

// File: tb/lcd_row_scan_test.sv
module lcd_row_scan_test;
  localparam int DIV = 4;
  localparam int NR  = 34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [1:0]    mux_code = 2'd0;
  logic          icon_mode = 1'b0;
  logic          power_down = 1'b1;
  logic          disp_en = 1'b0;
  logic [NR-1:0] row_sel;
  logic [5:0]    row_idx;
  logic          row_valid;
  logic          frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  lcd_row_scan #(.ICON_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .tick(tick), .mux_code(mux_code), .icon_mode(icon_mode),
    .power_down(power_down), .disp_en(disp_en), .row_sel(row_sel), .row_idx(row_idx),
    .row_valid(row_valid), .frame_start(frame_start)
  );

  // Behavioural reference: row order queue rebuilt at each frame start
  int m_act, m_pos, m_icon, m_cnt, m_fs;
  int order[$];

  function automatic int rows_of(input logic [1:0] c, input logic ic);
    if (ic) return 2;
    if (c == 2'd0) return 17;
    if (c == 2'd1) return 26;
    return 34;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_pos = 0; m_icon = 0; m_cnt = 0; m_fs = 0;
      order.delete();
    end else begin
      m_fs = 0;
      if (power_down || !disp_en) begin
        m_act = 0; m_pos = 0; m_cnt = 0;
      end else if (tick) begin
        if (!m_act || !m_icon || m_cnt == DIV - 1) begin
          m_cnt = 0;
          if (!m_act || m_pos == order.size() - 1) begin
            int n;
            n = rows_of(mux_code, icon_mode);
            m_icon = icon_mode;
            order.delete();
            for (int e = 0; e < n; e += 2) order.push_back(e);
            for (int o = 1; o < n; o += 2) order.push_back(o);
            m_act = 1; m_pos = 0; m_fs = 1;
          end else begin
            m_pos++;
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [NR-1:0] a, input logic [NR-1:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
  endtask

  task automatic compare_all();
    logic [NR-1:0] es;
    int ei;
    es = '0; ei = 0;
    if (m_act != 0) begin
      ei = order[m_pos];
      es[ei] = 1'b1;
    end
    check({phase, " row_sel"}, row_sel, es);
    check({phase, " row_idx"}, NR'(row_idx), NR'(ei));
    check({phase, " row_valid"}, NR'(row_valid), NR'(m_act != 0));
    check({phase, " frame_start"}, NR'(frame_start), NR'(m_fs));
  endtask

  task automatic run_cycles(input int n, input int tick_every);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      tick = ((k % tick_every) == 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset row_sel", row_sel, '0);
    check("R1 reset valid", NR'(row_valid), '0);
    rst = 1'b0;
    phase = "R1";
    run_cycles(4, 1);
    check("R1 idle after reset", row_sel, '0);

    // enable: first tick starts a frame at row 0
    @(negedge clk);
    power_down = 1'b0; disp_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    check("R5 first row is 0", NR'(row_idx), NR'(0));
    check("R5 frame pulse", NR'(frame_start), NR'(1));
    compare_all();
    @(negedge clk);
    check("R2 second row is 2", NR'(row_idx), NR'(2));
    check("R5 pulse one cycle", NR'(frame_start), NR'(0));
    phase = "R2"; run_cycles(40, 1);

    phase = "R4"; run_cycles(30, 3);
    phase = "R4"; run_cycles(12, 1);

    // mid-frame rate change takes effect only at next frame
    phase = "R8"; mux_code = 2'd2; run_cycles(60, 1);
    phase = "R3"; mux_code = 2'd1; run_cycles(60, 1);
    phase = "R3"; mux_code = 2'd3; run_cycles(80, 1);

    phase = "R6"; icon_mode = 1'b1; run_cycles(80, 1);
    phase = "R6"; run_cycles(40, 2);
    phase = "R8"; icon_mode = 1'b0; mux_code = 2'd0; run_cycles(30, 1);

    phase = "R7"; power_down = 1'b1; run_cycles(10, 1);
    check("R7 dark in power-down", row_sel, '0);
    power_down = 1'b0; run_cycles(20, 1);
    disp_en = 1'b0; run_cycles(10, 1);
    check("R7 dark when disabled", row_sel, '0);
    disp_en = 1'b1; run_cycles(40, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule